// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control Register

This block holds the 16-bit basic-mode control word of an Ethernet PHY and drives its fields as plain control levels to the rest of the PHY: link speed, duplex, auto-negotiation enable, loopback, low-power, isolate and collision test. A management frame decoder, outside this block, presents a register index, a write strobe with a data word, and takes the read word back combinationally. The management port has no handshake. A write is taken in the cycle its strobe is high, unless a software reset is running, in which case it is dropped. Reads never stall.

Setting the top bit starts a software reset. For a fixed number of clocks, the control fields are held at their defaults and a busy level is driven so that the PHY state machines return to idle. During that time, management writes are dropped and the top bit reads as 1. Writing 1 to the restart bit produces a single-cycle pulse for the auto-negotiation engine. The isolate default comes from the strapped PHY address.

Top module: `phy_basic_ctrl`

## Requirements
- R1: On hardware reset, the word read at index 0 is 0x3400 when `phy_addr` is 0 and 0x3000 for any other address. The control outputs match that word.
- R2: After a write without bit 15, the read word shows the written values of bits 14 (loopback), 13 (100 Mb/s when 1), 12 (auto-negotiation enable), 11 (low power), 10 (isolate), 8 (full duplex) and 7 (collision test). The output of the same name follows each bit.
- R3: Bits 6..0 always read as 0, and writes to them have no effect.
- R4: Writing bit 9 as 1 raises `aneg_restart` for exactly one cycle, the cycle after the write edge. Writing bit 9 as 0 raises no pulse. Bit 9 always reads as 0.
- R5: A write with bit 15 set raises `sw_reset_busy` for RESET_CYCLES cycles (default 16). Bit 15 reads as 1 for exactly those cycles. After them, writes take effect again.
- R6: While `sw_reset_busy` is high, writes are dropped and raise no restart pulse. The read word is 0x8000 OR'd with the default word of R1.
- R7: A write that sets bit 15 ignores its other bits. When the reset ends, the word equals the R1 default for the current `phy_addr`.
- R8: A write to any index other than 0 changes nothing, and a read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| phy_addr | input | 5 | Strapped PHY address |
| reg_addr | input | 5 | Management register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Read word for `reg_addr` (combinational) |
| loopback_en | output | 1 | Loopback enable |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| aneg_enable | output | 1 | Auto-negotiation enable |
| low_power | output | 1 | Low-power mode |
| isolate | output | 1 | Isolate from the MAC side |
| full_duplex | output | 1 | 1 = full duplex |
| col_test | output | 1 | Collision test enable |
| aneg_restart | output | 1 | One-cycle auto-negotiation restart pulse |
| sw_reset_busy | output | 1 | High while the software reset runs |

## Verification
The hardest case to reach from the ports is a management write that lands inside the software-reset window. The stimulus first writes a word that sets bit 15 along with every other bit. While the busy level is high, it then writes a word that sets the restart bit and the duplex bit. The bench checks that this write leaves no trace and raises no pulse. It also counts the busy cycles one by one and reads the default word back once the window closes.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int CTL_W = 16;
  localparam int B_SRST = 15;
  localparam int B_LOOP = 14;
  localparam int B_SPD = 13;
  localparam int B_ANEN = 12;
  localparam int B_LPWR = 11;
  localparam int B_ISO = 10;
  localparam int B_RSTRT = 9;
  localparam int B_FDX = 8;
  localparam int B_COLT = 7;

  typedef struct packed {
    logic loopback;
    logic speed_100;
    logic aneg_en;
    logic low_power;
    logic isolate;
    logic full_duplex;
    logic col_test;
  } ctl_fields_t;

  function automatic ctl_fields_t ctl_defaults(input logic [4:0] addr);
    ctl_fields_t f;
    f = '0;
    f.speed_100 = 1'b1;
    f.aneg_en = 1'b1;
    f.isolate = (addr == 5'd0);
    return f;
  endfunction

  function automatic ctl_fields_t ctl_unpack(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.loopback = w[B_LOOP];
    f.speed_100 = w[B_SPD];
    f.aneg_en = w[B_ANEN];
    f.low_power = w[B_LPWR];
    f.isolate = w[B_ISO];
    f.full_duplex = w[B_FDX];
    f.col_test = w[B_COLT];
    return f;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_fields_t f, input logic busy);
    logic [CTL_W-1:0] w;
    w = '0;
    w[B_SRST] = busy;
    w[B_LOOP] = f.loopback;
    w[B_SPD] = f.speed_100;
    w[B_ANEN] = f.aneg_en;
    w[B_LPWR] = f.low_power;
    w[B_ISO] = f.isolate;
    w[B_FDX] = f.full_duplex;
    w[B_COLT] = f.col_test;
    return w;
  endfunction
endpackage

// File: rtl/phy_ctl_rst_seq.sv
module phy_ctl_rst_seq #(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (RESET_CYCLES < 2) ? 1 : $clog2(RESET_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(RESET_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      remain <= '0;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      remain <= LOAD;
    end
  end

  // The top must never request a new sequence while one is running.
  assert_no_restart_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // The window closes only once the countdown has run out.
  assert_window_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && remain != '0) |=> busy);
endmodule

// File: rtl/phy_ctl_fields.sv
module phy_ctl_fields
  import phy_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        phy_addr,
  input  logic              load_dflt,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  output ctl_fields_t       q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ctl_defaults(phy_addr);
    else if (load_dflt) q <= ctl_defaults(phy_addr);
    else if (wr_en) q <= ctl_unpack(wr_data);
  end

  // With no write and no default load, the fields hold their values.
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !load_dflt) |=> $stable(q));
endmodule

// File: rtl/phy_ctl_restart.sv
module phy_ctl_restart (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else pulse <= fire;
  end

  assert_pulse_follows_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !pulse);
endmodule

// File: rtl/phy_basic_ctrl.sv
module phy_basic_ctrl
  import phy_ctl_pkg::*;
#(
  parameter int RESET_CYCLES = 16,
  parameter int REG_INDEX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        loopback_en,
  output logic        speed_100,
  output logic        aneg_enable,
  output logic        low_power,
  output logic        isolate,
  output logic        full_duplex,
  output logic        col_test,
  output logic        aneg_restart,
  output logic        sw_reset_busy
);
  localparam logic [4:0] IDX = 5'(REG_INDEX);

  logic        hit;
  logic        wr_ok;
  logic        srst_start;
  logic        field_wr;
  logic        load_dflt;
  logic        restart_fire;
  logic        busy;
  ctl_fields_t fq;

  assign hit = (reg_addr == IDX);
  assign wr_ok = wr_en && hit && !busy;
  assign srst_start = wr_ok && wr_data[B_SRST];
  assign field_wr = wr_ok && !wr_data[B_SRST];
  assign load_dflt = srst_start || busy;
  assign restart_fire = field_wr && wr_data[B_RSTRT];

  phy_ctl_rst_seq #(.RESET_CYCLES(RESET_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(busy)
  );

  phy_ctl_fields u_fields (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .load_dflt(load_dflt),
    .wr_en(field_wr), .wr_data(wr_data), .q(fq)
  );

  phy_ctl_restart u_rst (
    .clk(clk), .rst_n(rst_n), .fire(restart_fire), .pulse(aneg_restart)
  );

  assign rd_data = hit ? ctl_pack(fq, busy) : '0;
  assign loopback_en = fq.loopback;
  assign speed_100 = fq.speed_100;
  assign aneg_enable = fq.aneg_en;
  assign low_power = fq.low_power;
  assign isolate = fq.isolate;
  assign full_duplex = fq.full_duplex;
  assign col_test = fq.col_test;
  assign sw_reset_busy = busy;

  assert_no_pulse_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !aneg_restart);

  assert_defaults_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (speed_100 && aneg_enable && !loopback_en && !low_power
              && !full_duplex && !col_test));

  assert_busy_reads_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && busy) |-> rd_data[B_SRST]);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:0] == 7'd0) && !rd_data[B_RSTRT]);
endmodule

// File: tb/sim_phy_basic_ctrl.sv
module sim_phy_basic_ctrl;
  localparam int RC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic loopback_en, speed_100, aneg_enable, low_power, isolate;
  logic full_duplex, col_test, aneg_restart, sw_reset_busy;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phy_basic_ctrl #(.RESET_CYCLES(RC), .REG_INDEX(0)) u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .loopback_en(loopback_en), .speed_100(speed_100), .aneg_enable(aneg_enable),
    .low_power(low_power), .isolate(isolate), .full_duplex(full_duplex),
    .col_test(col_test), .aneg_restart(aneg_restart), .sw_reset_busy(sw_reset_busy)
  );

  function automatic logic [15:0] outs_word();
    return {1'b0, loopback_en, speed_100, aneg_enable, low_power, isolate,
            1'b0, full_duplex, col_test, 7'd0};
  endfunction

  function automatic logic [15:0] dflt(input logic [4:0] a);
    return (a == 5'd0) ? 16'h3400 : 16'h3000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw_reset(input logic [4:0] a);
    @(negedge clk);
    rst_n = 1'b0;
    phy_addr = a;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    reg_addr = 5'd0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: defaults after hardware reset for every strapped address
    for (int a = 0; a < 32; a++) begin
      hw_reset(5'(a));
      check("R1 read", rd_data, dflt(5'(a)));
      check("R1 outputs", outs_word(), dflt(5'(a)));
      check("R1 busy", {15'd0, sw_reset_busy}, 16'd0);
    end

    // R2 R3 R4: sweep all values of bits 14..7 with varied reserved bits
    hw_reset(5'd3);
    for (int v = 0; v < 256; v++) begin
      logic [15:0] d;
      logic [15:0] exp_w;
      d = {1'b0, 8'(v), 7'((v * 13 + 5) % 128)};
      exp_w = d & 16'h7D80;
      @(negedge clk);
      do_write(5'd0, d);
      check("R2 R3 read", rd_data, exp_w);
      check("R2 outputs", outs_word(), exp_w);
      check("R4 pulse", {15'd0, aneg_restart}, {15'd0, d[9]});
      @(negedge clk);
      #1;
      check("R4 single", {15'd0, aneg_restart}, 16'd0);
    end

    // R8: other index is ignored on write and reads as 0
    @(negedge clk);
    do_write(5'd0, 16'h0180);
    @(negedge clk);
    do_write(5'd2, 16'h4200);
    check("R8 no pulse", {15'd0, aneg_restart}, 16'd0);
    check("R8 unchanged", rd_data, 16'h0180);
    reg_addr = 5'd2;
    #1;
    check("R8 read other", rd_data, 16'h0000);
    reg_addr = 5'd0;

    // R5 R6 R7: software reset with a write landing inside the window
    for (int a = 0; a < 2; a++) begin
      int cyc;
      logic [4:0] pa;
      pa = (a == 0) ? 5'd0 : 5'd9;
      hw_reset(pa);
      @(negedge clk);
      do_write(5'd0, 16'h4980);
      check("R2 pre", rd_data, 16'h4980);
      @(negedge clk);
      do_write(5'd0, 16'hFFFF);
      check("R7 no pulse", {15'd0, aneg_restart}, 16'd0);
      check("R6 busy read", rd_data, 16'h8000 | dflt(pa));
      check("R5 busy", {15'd0, sw_reset_busy}, 16'd1);
      do_write(5'd0, 16'h0300);
      check("R6 dropped write", rd_data, 16'h8000 | dflt(pa));
      check("R6 no pulse", {15'd0, aneg_restart}, 16'd0);
      cyc = 2;
      forever begin
        @(negedge clk);
        #1;
        if (!sw_reset_busy) break;
        cyc++;
        if (cyc > RC + 4) break;
      end
      check("R5 window length", 16'(cyc), 16'(RC));
      check("R7 defaults after", rd_data, dflt(pa));
      check("R7 outputs after", outs_word(), dflt(pa));
      @(negedge clk);
      do_write(5'd0, 16'h0100);
      check("R5 access restored", rd_data, 16'h0100);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule